// File: doc/BRIEF.md
# Dual-Edge Lane Demultiplexer with Ping-Pong Block Store

This block takes four narrow sample channels that arrive on only two data lanes. Each lane carries two channels, one after the other, and its value changes on both edges of an accompanying strobe. The first channel of a lane is captured on the rising strobe edge and the second on the falling edge. Each captured pair is packed into one complex sample word: the first channel is the real part in the upper nibble and the second channel is the imaginary part in the lower nibble. The word is then moved into the system clock domain through a toggle and a two-flop synchroniser.

For each lane, the block writes words into one of two block banks of `DEPTH` entries. When a bank is full and the consumer holds no bank, the block hands the full bank to the consumer. It does this with a one-cycle ready pulse and a bank select. Filling then continues in the other bank. The consumer reads the held bank through a registered read port and releases it with a done pulse. A bank can fill while the consumer still holds the other bank. In that case a sticky overflow flag is raised, the new block is discarded, and filling starts again at address 0 of the same bank. The bank being read is never overwritten. Every pair is also sent out on a raw-sample stream for bulk storage.

Top module: `lane_pair_buffer`

## Requirements
- R1: While reset is asserted and after it is released, `blockReady`, `rawValid` and `overflow` are 0 until samples arrive.
- R2: For each lane, the value present at the rising strobe edge is the real part, bits [7:4] of the lane word. The value present at the following falling edge is the imaginary part, bits [3:0].
- R3: Each strobe period gives exactly one `rawValid` pulse. With it, `rawData[15:8]` holds the word of lane A and `rawData[7:0]` holds the word of lane B. Pulses come in arrival order.
- R4: The first bank filled after reset is bank 0. The words of a block are stored at consecutive addresses 0 to `DEPTH-1`.
- R5: When the `DEPTH`-th word of a block is stored and no bank is held, `blockReady` pulses for one cycle. At the same time, `readyBank` names the bank just filled, and filling moves to the other bank.
- R6: The read port returns, one clock after `rdAddr` is applied, the words of lanes A and B stored at that address in the bank named by `readyBank`.
- R7: If a block completes while the consumer still holds a bank, `overflow` becomes 1 and stays 1 until reset. No `blockReady` pulse is given, and the held bank's contents are unchanged.
- R8: A `doneIn` pulse releases the held bank. After a dropped block, the next complete block is stored from address 0 of the fill bank and is reported ready in that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Lane strobe; data is captured on both of its edges |
| laneA | input | 4 | Lane carrying the first channel pair |
| laneB | input | 4 | Lane carrying the second channel pair |
| doneIn | input | 1 | One-cycle pulse from the consumer releasing the held bank |
| rdAddr | input | 8 | Read address in the held bank |
| rawValid | output | 1 | One-cycle pulse, raw sample available |
| rawData | output | 16 | Raw sample: lane A word, then lane B word |
| blockReady | output | 1 | One-cycle pulse, a full block is handed over |
| readyBank | output | 1 | Bank currently held by the consumer |
| overflow | output | 1 | Sticky: a block was dropped |
| rdWordA | output | 8 | Lane A word read from the held bank |
| rdWordB | output | 8 | Lane B word read from the held bank |

## Verification
The two lanes are driven with different patterns: lane A uses an incrementing, block-offset sequence and lane B uses an inverted, scaled one. A swap of lanes, a swap of strobe edges, or an exchange of nibbles therefore gives a wrong value in both the raw stream and the read-back. The sequence of four blocks has three stages:
- An ordinary handoff, read back and then released.
- A held bank followed by a further complete block. This shows that the overflow path drops the new data, gives no ready pulse, and leaves the held data unchanged.
- A block after the release. This shows that filling restarts at address 0 in the correct bank.

// File: rtl/lpb_pkg.sv
`timescale 1ns/1ps
package lpb_pkg;
  // strobes from bank control to the block store
  typedef struct packed {
    logic wrEn;
    logic wrBank;
    logic rdBank;
  } bankCtl_t;
endpackage

// File: rtl/lpb_edge_capture.sv
`timescale 1ns/1ps
module lpb_edge_capture #(
  parameter int NIB_W = 4,
  parameter int LANES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       strobe,
  input  logic [LANES*NIB_W-1:0]     lanes,
  output logic                       newPair,
  output logic [LANES*2*NIB_W-1:0]   pairWord
);
  localparam int WORD_W = 2 * NIB_W;

  logic [LANES*NIB_W-1:0]   firstQ;
  logic [LANES*WORD_W-1:0]  pairQ;
  logic                     pairTgl;
  logic [2:0]               syncQ;

  // real part on the rising strobe edge
  always_ff @(posedge strobe or negedge rstN) begin
    if (!rstN) firstQ <= '0;
    else       firstQ <= lanes;
  end

  // imaginary part on the falling edge; the whole pair is published here
  always_ff @(negedge strobe or negedge rstN) begin
    if (!rstN) begin
      pairQ   <= '0;
      pairTgl <= 1'b0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        pairQ[l*WORD_W +: WORD_W] <= {firstQ[l*NIB_W +: NIB_W], lanes[l*NIB_W +: NIB_W]};
      end
      pairTgl <= ~pairTgl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], pairTgl};
  end

  assign newPair  = syncQ[1] ^ syncQ[2];
  assign pairWord = pairQ;   // held stable for a full strobe period
endmodule

// File: rtl/lpb_bank_ctrl.sv
`timescale 1ns/1ps
module lpb_bank_ctrl
  import lpb_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              newPair,
  input  logic              doneIn,
  output bankCtl_t          ctl,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              blockReady,
  output logic              readyBank,
  output logic              overflow
);
  logic [ADDR_W-1:0] cnt;
  logic fillBank, held, heldBank;
  logic blockEnd, heldEff;

  assign blockEnd = newPair && (cnt == ADDR_W'(DEPTH - 1));
  assign heldEff  = held && !doneIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      fillBank   <= 1'b0;
      held       <= 1'b0;
      heldBank   <= 1'b0;
      blockReady <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      blockReady <= 1'b0;
      if (newPair) cnt <= blockEnd ? '0 : cnt + 1'b1;
      if (doneIn) held <= 1'b0;
      if (blockEnd) begin
        if (!heldEff) begin
          held       <= 1'b1;
          heldBank   <= fillBank;
          fillBank   <= ~fillBank;
          blockReady <= 1'b1;
        end else begin
          overflow   <= 1'b1;   // drop: refill same bank from 0
        end
      end
    end
  end

  assign ctl.wrEn   = newPair;
  assign ctl.wrBank = fillBank;
  assign ctl.rdBank = heldBank;
  assign wrAddr     = cnt;
  assign readyBank  = heldBank;

  p_no_write_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> !(held && ctl.wrBank == heldBank));
  p_ready_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    blockReady |-> held);
  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  p_done_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && !blockEnd) |=> !held);
  p_swap_on_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    blockReady |-> (fillBank != heldBank));
endmodule

// File: rtl/lpb_bank_store.sv
`timescale 1ns/1ps
module lpb_bank_store
  import lpb_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 8,
  parameter int LANES  = 2,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bankCtl_t                ctl,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES*WORD_W-1:0] pairWord,
  output logic [LANES*WORD_W-1:0] rdWords,
  output logic                    rawValid,
  output logic [LANES*WORD_W-1:0] rawData
);
  localparam int SLOTS = 2 * DEPTH;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] mem [SLOTS];
    logic [WORD_W-1:0] rdQ;

    always_ff @(posedge clk) begin
      if (ctl.wrEn) mem[{ctl.wrBank, wrAddr}] <= pairWord[g*WORD_W +: WORD_W];
      rdQ <= mem[{ctl.rdBank, rdAddr}];
    end
    assign rdWords[g*WORD_W +: WORD_W] = rdQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawValid <= 1'b0;
      rawData  <= '0;
    end else begin
      rawValid <= ctl.wrEn;
      if (ctl.wrEn) rawData <= pairWord;
    end
  end

  p_raw_follows_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> rawValid);
  p_raw_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    rawValid |-> !$past(rawValid));
endmodule

// File: rtl/lane_pair_buffer.sv
`timescale 1ns/1ps
module lane_pair_buffer
  import lpb_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 strobe,
  input  logic [NIB_W-1:0]     laneA,
  input  logic [NIB_W-1:0]     laneB,
  input  logic                 doneIn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic                 rawValid,
  output logic [4*NIB_W-1:0]   rawData,
  output logic                 blockReady,
  output logic                 readyBank,
  output logic                 overflow,
  output logic [2*NIB_W-1:0]   rdWordA,
  output logic [2*NIB_W-1:0]   rdWordB
);
  localparam int WORD_W = 2 * NIB_W;
  localparam int LANES  = 2;

  logic                    newPair;
  logic [LANES*WORD_W-1:0] pairWord, rdWords;
  logic [ADDR_W-1:0]       wrAddr;
  bankCtl_t                ctl;

  lpb_edge_capture #(.NIB_W(NIB_W), .LANES(LANES)) u_cap (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lanes({laneA, laneB}),
    .newPair(newPair), .pairWord(pairWord));

  lpb_bank_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .newPair(newPair), .doneIn(doneIn),
    .ctl(ctl), .wrAddr(wrAddr), .blockReady(blockReady),
    .readyBank(readyBank), .overflow(overflow));

  lpb_bank_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .pairWord(pairWord), .rdWords(rdWords), .rawValid(rawValid), .rawData(rawData));

  assign rdWordA = rdWords[WORD_W +: WORD_W];
  assign rdWordB = rdWords[0 +: WORD_W];
endmodule

// File: tb/lane_pair_buffer_tb.sv
`timescale 1ns/1ps
module lane_pair_buffer_tb;
  localparam int DEPTH = 256;

  logic clk = 0, rstN = 0, strobe = 0, doneIn = 0;
  logic [3:0] laneA = 0, laneB = 0;
  logic [7:0] rdAddr = 0;
  logic rawValid, blockReady, readyBank, overflow;
  logic [15:0] rawData;
  logic [7:0] rdWordA, rdWordB;

  int checks = 0, fails = 0, readyCnt = 0;
  bit readyBankSeen;
  logic [15:0] rawQ[$];

  always #2 clk = ~clk;   // 250 MHz

  lane_pair_buffer u_dut (
    .clk(clk), .rstN(rstN), .strobe(strobe), .laneA(laneA), .laneB(laneB),
    .doneIn(doneIn), .rdAddr(rdAddr), .rawValid(rawValid), .rawData(rawData),
    .blockReady(blockReady), .readyBank(readyBank), .overflow(overflow),
    .rdWordA(rdWordA), .rdWordB(rdWordB));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wordA(int b, int i); return 8'((b * 37 + i) & 255); endfunction
  function automatic logic [7:0] wordB(int b, int i); return ~8'((i * 3 + b * 11) & 255); endfunction

  // driver: real part before the rising edge, imaginary part before the falling edge
  task automatic sendPair(input logic [7:0] wa, input logic [7:0] wb);
    rawQ.push_back({wa, wb});
    laneA = wa[7:4]; laneB = wb[7:4];
    #10 strobe = 1;
    #5  laneA = wa[3:0]; laneB = wb[3:0];
    #5  strobe = 0;
    #20;
  endtask

  task automatic sendBlock(input int b);
    for (int i = 0; i < DEPTH; i++) sendPair(wordA(b, i), wordB(b, i));
    repeat (8) @(negedge clk);
  endtask

  task automatic readBlock(input int b, input logic bank, input string req);
    check(readyBank == bank, req, readyBank, bank);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk) rdAddr = 8'(i);
      @(negedge clk);
      check(rdWordA == wordA(b, i), req, rdWordA, wordA(b, i));
      check(rdWordB == wordB(b, i), req, rdWordB, wordB(b, i));
    end
  endtask

  task automatic pulseDone();
    @(negedge clk) doneIn = 1;
    @(negedge clk) doneIn = 0;
  endtask

  // monitor: raw stream scoreboard (R2, R3) and ready pulses
  always @(negedge clk) begin
    if (rstN && rawValid) begin
      if (rawQ.size() == 0) check(1'b0, "R3 unexpected raw", rawData, 0);
      else begin
        logic [15:0] e;
        e = rawQ.pop_front();
        check(rawData == e, "R2/R3 raw word", rawData, e);
      end
    end
    if (rstN && blockReady) begin
      readyCnt++;
      readyBankSeen = readyBank;
    end
  end

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(blockReady == 0 && rawValid == 0 && overflow == 0, "R1 in reset",
          {blockReady, rawValid, overflow}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(blockReady == 0 && rawValid == 0 && overflow == 0, "R1 after reset",
          {blockReady, rawValid, overflow}, 0);

    // block 0: normal handoff into bank 0 (R4, R5, R6)
    sendBlock(0);
    check(readyCnt == 1, "R5 ready count", readyCnt, 1);
    check(readyBankSeen == 1'b0, "R4 first bank", readyBankSeen, 0);
    readBlock(0, 1'b0, "R6 block0 readback");
    pulseDone();

    // block 1 into bank 1, kept held
    sendBlock(1);
    check(readyCnt == 2, "R5 ready count b1", readyCnt, 2);
    check(readyBankSeen == 1'b1, "R5 swap to bank1", readyBankSeen, 1);
    check(overflow == 0, "R7 no overflow yet", overflow, 0);

    // block 2 completes while bank 1 held: dropped
    sendBlock(2);
    check(overflow == 1, "R7 overflow set", overflow, 1);
    check(readyCnt == 2, "R7 no ready on drop", readyCnt, 2);
    readBlock(1, 1'b1, "R7 held bank intact");
    pulseDone();
    check(overflow == 1, "R7 overflow sticky", overflow, 1);

    // block 3 restarts at address 0 of bank 0
    sendBlock(3);
    check(readyCnt == 3, "R8 ready after release", readyCnt, 3);
    check(readyBankSeen == 1'b0, "R8 bank0 after drop", readyBankSeen, 0);
    readBlock(3, 1'b0, "R8 block3 readback");
    check(rawQ.size() == 0, "R3 all raw seen", rawQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule